// File: doc/BRIEF.md
# SPI Memory Slave Front-End with Pause Control

This block is the serial front end of a byte-addressed memory slave. It runs on a fast system clock and samples the SPI pins as ordinary inputs. From the serial stream it recovers an opcode byte, a two-byte address and any number of data bytes. It hands these to the memory side as one-cycle strobes. For reads, it takes one byte at a time from the memory side and shifts it out MSB-first on the serial output, which has a separate drive enable.

It works with both SPI clock idle levels (modes 0 and 3) and needs no configuration for either. A pause input can freeze a transfer in the middle of a frame. While paused, clock edges are ignored, all frame state is kept and the serial output is released. The byte pointer advances after every data byte and wraps at the top of the address space. The write-protect pin is only synchronised and passed on. All pins pass through a two-stage synchroniser, so the system clock must run at least four times the serial clock rate.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset, and whenever chip select (active low) is high, so_oe is 0, no strobe is raised, and the next frame starts again at its opcode byte.
- R2: The first 8 bits of a frame are sampled on SCK rising edges, MSB first. They are presented on op_code with a one-cycle op_valid pulse.
- R3: The next two bytes form the address, high byte first. Only the low 15 bits are kept, so bit 7 of the first address byte is ignored. A one-cycle addr_valid pulse marks completion, and mem_addr then shows that address.
- R4: Each later byte received is presented on wr_data with a one-cycle wr_valid pulse and its byte address on wr_addr. After every data byte, mem_addr advances by one and wraps from 0x7FFF to 0x0000.
- R5: In the data phase, rd_data is taken for mem_addr on the SCK falling edge that comes before each data byte. It is shifted out MSB first, and so changes only in response to SCK falling edges.
- R6: so_oe is 1 only while chip select is low, the transfer is not paused, and the address has been fully received.
- R7: Frames work the same with SCK idling low (mode 0) or high (mode 3). A falling edge before the first rising edge has no effect.
- R8: hold_n low pauses the transfer only once SCK is low, and the pause ends only when hold_n is high with SCK low. While paused, SCK edges are ignored, the received bits and position are kept, and so_oe is 0.
- R9: Raising chip select in the middle of a byte drops the partial frame. The next frame starts with a fresh opcode byte and address.
- R10: wp_n_sync follows wp_n with the same two-stage synchroniser delay as the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect pin, passed through |
| rd_data | input | 8 | Read byte for mem_addr from the memory side |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| op_valid | output | 1 | Opcode byte received |
| op_code | output | 8 | Last opcode byte |
| addr_valid | output | 1 | Address complete |
| mem_addr | output | 15 | Current byte pointer |
| wr_valid | output | 1 | Data byte received |
| wr_data | output | 8 | Received data byte |
| wr_addr | output | 15 | Address of the received data byte |
| wp_n_sync | output | 1 | Synchronised write-protect |

## Verification
Entering a pause and an SCK falling edge can land in the same system cycle. The falling edge that releases SCK low is also the one that moves the next read bit onto so. The bench lowers hold_n while SCK is high and then drops SCK, so both take effect together. The cycle model requires that this edge's shift still happens and that so_oe is deasserted only after it. After the pause is released, the bits the host receives must continue the byte without a skip or a repeat.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_AHI  = 2'd1,
    PH_ALO  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  if (STAGES == 1) begin : g_single
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) r <= RST_VAL;
      else        r <= d;
    assign q = r;
  end else begin : g_chain
    logic [CHAIN_W-1:0] chain;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
    assign q = chain[CHAIN_W-1 -: W];
  end
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_fe_oshift.sv
module spi_fe_oshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  assign msb = sr[W-1];
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic              wp_n,
  input  logic [7:0]        rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              op_valid,
  output logic [7:0]        op_code,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wp_n_sync
);
  localparam int             NIN    = 5;
  localparam logic [NIN-1:0] IN_RST = 5'b11001; // {wp,hold,si,sck,cs}
  localparam int             BIT_W  = $clog2(BYTE_W);

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[ADDR_W-1:0];
  endfunction

  // pin synchronisation
  logic [NIN-1:0] pins_s;
  spi_fe_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({wp_n, hold_n, si, sck, cs_n}), .q(pins_s)
  );
  logic cs_s, sck_s, si_s, hold_s;
  assign cs_s   = pins_s[0];
  assign sck_s  = pins_s[1];
  assign si_s   = pins_s[2];
  assign hold_s = pins_s[3];
  assign wp_n_sync = pins_s[4];

  logic sck_rise, sck_fall;
  spi_fe_edge #(.RST_VAL(1'b0)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise), .fall(sck_fall)
  );

  // frame state
  logic             act, held;
  phase_t           st;
  logic [BIT_W-1:0] bit_idx;
  logic [7:0]       in_sr, addr_hi;
  logic [ADDR_W-1:0] ptr;

  assign act = ~cs_s;

  // named events
  logic       take_bit, byte_done, out_load, out_shift, hold_enter, hold_leave;
  logic [7:0] byte_now;
  assign take_bit   = act & ~held & sck_rise;
  assign byte_now   = {in_sr[6:0], si_s};
  assign byte_done  = take_bit & (bit_idx == BIT_W'(BYTE_W-1));
  assign out_load   = act & ~held & sck_fall & (st == PH_DATA) & (bit_idx == '0);
  assign out_shift  = act & ~held & sck_fall & (st == PH_DATA) & (bit_idx != '0);
  assign hold_enter = act & ~held & ~hold_s & ~sck_s;
  assign hold_leave = act &  held &  hold_s & ~sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_OPC; bit_idx <= '0; held <= 1'b0;
      in_sr <= '0; addr_hi <= '0; ptr <= '0;
      op_valid <= 1'b0; op_code <= '0; addr_valid <= 1'b0;
      wr_valid <= 1'b0; wr_data <= '0; wr_addr <= '0;
    end else begin
      op_valid   <= 1'b0;
      addr_valid <= 1'b0;
      wr_valid   <= 1'b0;
      if (!act) begin
        st <= PH_OPC; bit_idx <= '0; held <= 1'b0;
      end else begin
        if (hold_enter)      held <= 1'b1;
        else if (hold_leave) held <= 1'b0;
        if (take_bit) begin
          in_sr   <= byte_now;
          bit_idx <= bit_idx + BIT_W'(1);
        end
        if (byte_done) begin
          case (st)
            PH_OPC:  begin op_code <= byte_now; op_valid <= 1'b1; st <= PH_AHI; end
            PH_AHI:  begin addr_hi <= byte_now; st <= PH_ALO; end
            PH_ALO:  begin ptr <= join_addr(addr_hi, byte_now); addr_valid <= 1'b1; st <= PH_DATA; end
            PH_DATA: begin
              wr_valid <= 1'b1; wr_data <= byte_now; wr_addr <= ptr;
              ptr <= next_addr(ptr);
            end
          endcase
        end
      end
    end
  end

  spi_fe_oshift #(.W(BYTE_W)) u_oshift (
    .clk(clk), .rst_n(rst_n), .load(out_load), .shift(out_shift), .din(rd_data), .msb(so)
  );

  assign so_oe    = act & ~held & (st == PH_DATA);
  assign mem_addr = ptr;

  // assertions
  a_r8_enter_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held && act) |=> (bit_idx == $past(bit_idx) && in_sr == $past(in_sr)));
  a_r5_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));
  a_r2_op_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (st == PH_AHI));
  a_r3_addr_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (st == PH_DATA && bit_idx == '0));
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (mem_addr == next_addr(wr_addr)));
endmodule

// File: tb/spi_mem_frontend_bench.sv
module spi_mem_frontend_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sck, si, hold_n, wp_n;
  logic [7:0]  rd_data;
  logic so, so_oe, op_valid, addr_valid, wr_valid, wp_n_sync;
  logic [7:0]  op_code, wr_data;
  logic [14:0] mem_addr, wr_addr;

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'hA5;
  endfunction
  assign rd_data = mem_byte(mem_addr);

  spi_mem_frontend u_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .rd_data(rd_data), .so(so), .so_oe(so_oe), .op_valid(op_valid),
    .op_code(op_code), .addr_valid(addr_valid), .mem_addr(mem_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr(wr_addr), .wp_n_sync(wp_n_sync)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model: pins seen through two sync stages
  localparam logic [4:0] PIN_RST = 5'b11001; // {wp,hold,si,sck,cs}
  logic [4:0] m_h1, m_h2, m_h3;
  int m_st, m_bit;
  bit m_held, m_opv, m_av, m_wv;
  logic [7:0]  m_sr, m_hi, m_osr, m_op, m_wd;
  logic [14:0] m_ptr, m_wa;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h1 = PIN_RST; m_h2 = PIN_RST; m_h3 = PIN_RST;
      m_st = 0; m_bit = 0; m_held = 0; m_opv = 0; m_av = 0; m_wv = 0;
      m_sr = 0; m_hi = 0; m_osr = 0; m_op = 0; m_wd = 0; m_ptr = 0; m_wa = 0;
    end else begin
      bit c, s, d, i, hl, was_held, rise, fall;
      logic [7:0] nb;
      c = m_h2[0]; s = m_h2[1]; d = m_h3[1]; i = m_h2[2]; hl = m_h2[3];
      rise = s & !d; fall = !s & d; was_held = m_held;
      m_opv = 0; m_av = 0; m_wv = 0;
      if (c) begin
        m_st = 0; m_bit = 0; m_held = 0;
      end else begin
        if (!was_held && !hl && !s) m_held = 1;
        else if (was_held && hl && !s) m_held = 0;
        if (!was_held && fall && m_st == 3) begin
          if (m_bit == 0) m_osr = mem_byte(m_ptr);
          else            m_osr = {m_osr[6:0], 1'b0};
        end
        if (!was_held && rise) begin
          nb = {m_sr[6:0], i}; m_sr = nb;
          if (m_bit == 7) begin
            m_bit = 0;
            if (m_st == 0)      begin m_op = nb; m_opv = 1; m_st = 1; end
            else if (m_st == 1) begin m_hi = nb; m_st = 2; end
            else if (m_st == 2) begin m_ptr = {m_hi[6:0], nb}; m_av = 1; m_st = 3; end
            else begin m_wv = 1; m_wd = nb; m_wa = m_ptr; m_ptr = m_ptr + 15'd1; end
          end else m_bit++;
        end
      end
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = {wp_n, hold_n, si, sck, cs_n};
    end
  end

  // every-cycle comparison, away from the active edge
  logic [22:0] wr_q[$];
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_oe;
      exp_oe = !m_h2[0] && !m_held && (m_st == 3);
      chk(so_oe == exp_oe, "R6", "so_oe", int'(so_oe), int'(exp_oe));
      if (exp_oe) chk(so == m_osr[7], "R5", "so", int'(so), int'(m_osr[7]));
      chk(op_valid == m_opv, "R2", "op_valid", int'(op_valid), int'(m_opv));
      if (m_opv) chk(op_code == m_op, "R2", "op_code", int'(op_code), int'(m_op));
      chk(addr_valid == m_av, "R3", "addr_valid", int'(addr_valid), int'(m_av));
      chk(mem_addr == m_ptr, "R4", "mem_addr", int'(mem_addr), int'(m_ptr));
      chk(wr_valid == m_wv, "R4", "wr_valid", int'(wr_valid), int'(m_wv));
      if (m_wv) begin
        chk(wr_data == m_wd, "R4", "wr_data", int'(wr_data), int'(m_wd));
        chk(wr_addr == m_wa, "R4", "wr_addr", int'(wr_addr), int'(m_wa));
      end
      chk(wp_n_sync == m_h2[4], "R10", "wp_n_sync", int'(wp_n_sync), int'(m_h2[4]));
      if (wr_valid) wr_q.push_back({wr_addr, wr_data});
    end
  end

  // host side
  bit mode3;
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bitx(input logic b, output logic r);
    sck = 1'b0; si = b; wait_clk(4);
    r = so; sck = 1'b1; wait_clk(4);
  endtask
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) bitx(tx[b], rx[b]);
  endtask
  task automatic frame_start(input bit m3);
    mode3 = m3; sck = m3; wait_clk(4); cs_n = 1'b0; wait_clk(4);
  endtask
  task automatic frame_end();
    wait_clk(2);
    if (!mode3) sck = 1'b0;
    wait_clk(4); cs_n = 1'b1; wait_clk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic r;
    logic [22:0] e;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    // R1 reset state
    chk(so_oe == 1'b0, "R1", "so_oe after reset", int'(so_oe), 0);
    chk(op_valid == 1'b0 && addr_valid == 1'b0 && wr_valid == 1'b0, "R1", "strobes after reset", 1, 0);

    // R2 R3 R5: mode 0 read of three bytes at 0x1234
    frame_start(1'b0);
    xfer(8'h03, rx); xfer(8'h12, rx); xfer(8'h34, rx);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx);
      chk(rx == mem_byte(15'h1234 + 15'(k)), "R5", "read byte mode 0", int'(rx), int'(mem_byte(15'h1234 + 15'(k))));
    end
    frame_end();
    chk(op_code == 8'h03, "R2", "opcode held", int'(op_code), 3);
    chk(mem_addr == 15'h1237, "R4", "pointer after 3 bytes", int'(mem_addr), 'h1237);
    chk(so_oe == 1'b0, "R1", "so_oe with cs high", int'(so_oe), 0);

    // R3 R4 R7: mode 3 write across the wrap, top address bit ignored
    wr_q.delete();
    frame_start(1'b1);
    xfer(8'h02, rx); xfer(8'hFF, rx); xfer(8'hFE, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx);
    frame_end();
    chk(wr_q.size() == 3, "R4", "write strobes", wr_q.size(), 3);
    if (wr_q.size() == 3) begin
      e = wr_q[0]; chk(e == {15'h7FFE, 8'h11}, "R3", "first write", int'(e), int'({15'h7FFE, 8'h11}));
      e = wr_q[1]; chk(e == {15'h7FFF, 8'h22}, "R4", "second write", int'(e), int'({15'h7FFF, 8'h22}));
      e = wr_q[2]; chk(e == {15'h0000, 8'h33}, "R4", "wrapped write", int'(e), int'({15'h0000, 8'h33}));
    end
    chk(op_code == 8'h02, "R7", "mode 3 opcode", int'(op_code), 2);
    chk(mem_addr == 15'h0001, "R4", "pointer after wrap", int'(mem_addr), 1);

    // R7 R4: mode 3 read across the wrap
    frame_start(1'b1);
    xfer(8'h03, rx); xfer(8'h7F, rx); xfer(8'hFF, rx);
    xfer(8'h00, rx); chk(rx == mem_byte(15'h7FFF), "R7", "mode 3 read top", int'(rx), int'(mem_byte(15'h7FFF)));
    xfer(8'h00, rx); chk(rx == mem_byte(15'h0000), "R4", "read after wrap", int'(rx), int'(mem_byte(15'h0000)));
    frame_end();

    // R8: pause requested with SCK high, taking effect together with the falling edge
    frame_start(1'b0);
    xfer(8'h03, rx); xfer(8'h01, rx); xfer(8'h00, rx);
    for (int b = 7; b >= 5; b--) begin bitx(1'b0, r); rx[b] = r; end
    hold_n = 1'b0; wait_clk(6);
    chk(so_oe == 1'b1, "R8", "pause waits for SCK low", int'(so_oe), 1);
    sck = 1'b0; wait_clk(6);
    chk(so_oe == 1'b0, "R8", "so_oe while paused", int'(so_oe), 0);
    for (int t = 0; t < 3; t++) begin sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(4); end
    chk(so_oe == 1'b0, "R8", "so_oe after ignored edges", int'(so_oe), 0);
    hold_n = 1'b1; wait_clk(6);
    chk(so_oe == 1'b1, "R8", "so_oe after release", int'(so_oe), 1);
    for (int b = 4; b >= 0; b--) begin bitx(1'b0, r); rx[b] = r; end
    chk(rx == mem_byte(15'h0100), "R8", "byte across pause", int'(rx), int'(mem_byte(15'h0100)));
    xfer(8'h00, rx);
    chk(rx == mem_byte(15'h0101), "R8", "byte after pause", int'(rx), int'(mem_byte(15'h0101)));
    frame_end();

    // R9: abort in the middle of an address byte
    frame_start(1'b0);
    xfer(8'hAA, rx);
    for (int b = 0; b < 4; b++) bitx(1'b1, r);
    frame_end();
    frame_start(1'b0);
    xfer(8'h05, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    frame_end();
    chk(op_code == 8'h05, "R9", "opcode after abort", int'(op_code), 5);
    chk(mem_addr == 15'h0010, "R9", "address after abort", int'(mem_addr), 'h10);

    // R10: write-protect pass-through
    wp_n = 1'b0; wait_clk(4);
    chk(wp_n_sync == 1'b0, "R10", "wp low", int'(wp_n_sync), 0);
    wp_n = 1'b1; wait_clk(4);
    chk(wp_n_sync == 1'b1, "R10", "wp high", int'(wp_n_sync), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule